// File: doc/BRIEF.md
# Parallel EPROM Read Cycle Controller

This block sits between a simple host request port and an 8K x 8 parallel read-only memory. The memory has separate active-low chip-enable and output-enable pins. The host offers a 13-bit byte address with a valid/ready handshake. The controller drives the address and lowers chip-enable in the same clock cycle. It lowers output-enable later, by a computed lag. It samples the data bus once all three access minimums are met, and returns the byte with a one-cycle valid strobe.

All memory timings are parameters given in nanoseconds, together with the clock period. Each one is turned into a whole number of cycles by rounding up, so every minimum is always met. Output-enable is delayed as far as it can go without lengthening the access: the lag equals the larger of the address and chip-enable delays minus the output-enable delay, and is zero if that difference is negative. After a read, both enables are released together. A float-recovery window then keeps the next access from starting while the memory may still be driving the bus.

With the default 20 ns clock and 200/200/100/50 ns timings, these counts are 10 cycles for the address delay, 10 for chip-enable, 5 for output-enable and 3 for float recovery. The output-enable lag is 5 cycles and the total access is 10 cycles.

Top module: `eprom_read_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From that edge on, `mem_addr` carries the request address and `mem_ce_n` is 0.
- R3: `mem_oe_n` falls exactly LAG cycles after `mem_ce_n` falls (5 by default), and is never 0 while `mem_ce_n` is 1.
- R4: `rsp_valid` is a single-cycle pulse. It rises exactly TOTAL cycles after `mem_ce_n` falls (10 by default). `rsp_data` then holds the value `mem_data` had at that edge, and keeps it until the next response.
- R5: `mem_ce_n` and `mem_oe_n` both return to 1 one cycle after `rsp_valid` rises. `mem_addr` stays stable for as long as `mem_ce_n` is 0.
- R6: After the enables are released, `req_ready` stays 0 long enough that the next fall of `mem_ce_n` comes at least OFF cycles later (3 by default). With a waiting request it comes exactly OFF cycles later.
- R7: A request offered while `req_ready` is 0 is ignored. Its address is not captured, `mem_ce_n` shows no activity for it, and no response is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 13 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` is new |
| rsp_data | output | 8 | Byte read from the memory |
| mem_addr | output | 13 | Address bus to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_data | input | 8 | Data bus from the memory |

## Verification
Addresses are sent in three patterns: back-to-back with a request always waiting, isolated with idle gaps between them, and with a second request held against a busy controller. Back-to-back traffic shows whether float recovery is exactly OFF cycles or longer. Isolated requests show that the idle and ready path starts an access cleanly. The held request tells an ignored request apart from one that is accepted late. The memory model returns the correct byte only when the address age, chip-enable age and output-enable age have each reached their minimum. If any of the three waits is cut short, the model returns 8'hEE, so the scoreboard detects the short wait and can tell it apart from a wrong address.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_e;

    // Round a nanosecond delay up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_phase.sv
// Counts cycles since chip-enable fell; flags the output-enable point and the sample point.
module eprom_rd_phase #(
    parameter int unsigned LAG   = 5,
    parameter int unsigned TOTAL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic oe_win_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(TOTAL + 1) < 1 ? 1 : $clog2(TOTAL + 1);
    localparam logic [CW-1:0] TOT_V = CW'(TOTAL);
    localparam logic [CW-1:0] LAG_V = CW'(LAG);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (start_i) begin
            cnt_d = CW'(1);
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign oe_win_o = (cnt_q >= LAG_V);
    assign done_o   = (cnt_q == TOT_V);

    // R4: the phase count never runs past the sample point
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOT_V);

endmodule

// File: rtl/eprom_rd_recover.sv
// Float-recovery down-counter: clear_o is 1 when a new access may start.
module eprom_rd_recover #(
    parameter int unsigned OFF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic clear_o
);
    localparam int unsigned LOADV = (OFF > 0) ? OFF - 1 : 0;
    localparam int unsigned FW    = (LOADV > 0) ? $clog2(LOADV + 1) : 1;

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = FW'(LOADV);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign clear_o = (cnt_q == '0);

    // R6: a release only happens once the previous window has run out
    a_r6_load_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> clear_o);

endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl #(
    parameter int unsigned AW        = 13,
    parameter int unsigned DW        = 8,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned T_ACC_NS  = 200,
    parameter int unsigned T_CE_NS   = 200,
    parameter int unsigned T_OE_NS   = 100,
    parameter int unsigned T_OFF_NS  = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    input  logic [DW-1:0] mem_data
);
    import eprom_rd_pkg::*;

    localparam int unsigned ACC_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned CE_CYC    = ns_to_cyc(T_CE_NS, CLK_NS);
    localparam int unsigned OE_CYC    = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int unsigned OFF_CYC   = ns_to_cyc(T_OFF_NS, CLK_NS);
    localparam int unsigned SETUP_CYC = umax(ACC_CYC, CE_CYC);
    localparam int unsigned LAG_CYC   = (SETUP_CYC > OE_CYC) ? SETUP_CYC - OE_CYC : 0;
    localparam int unsigned TOTAL_CYC = umax(LAG_CYC + OE_CYC, 1);
    localparam logic        OE_LATE   = (LAG_CYC != 0);

    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] addr;
        logic          ce_n;
        logic          oe_n;
        logic          vld;
        logic [DW-1:0] data;
    } regs_t;

    regs_t r_d, r_q;
    logic  accept, oe_win, done, clear;

    assign req_ready = (r_q.st == ST_IDLE) && clear;
    assign accept    = req_valid && req_ready;

    eprom_rd_phase #(
        .LAG   (LAG_CYC),
        .TOTAL (TOTAL_CYC)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .run_i    ((r_q.st == ST_ACCESS) && !done),
        .oe_win_o (oe_win),
        .done_o   (done)
    );

    eprom_rd_recover #(
        .OFF (OFF_CYC)
    ) u_recover (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (r_q.st == ST_RELEASE),
        .clear_o (clear)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st   = ST_ACCESS;
                    r_d.addr = req_addr;
                    r_d.ce_n = 1'b0;
                    r_d.oe_n = OE_LATE;
                end
            end
            ST_ACCESS: begin
                if (oe_win) begin
                    r_d.oe_n = 1'b0;
                end
                if (done) begin
                    r_d.data = mem_data;
                    r_d.vld  = 1'b1;
                    r_d.st   = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                r_d.ce_n = 1'b1;
                r_d.oe_n = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.ce_n = 1'b1;
                r_d.oe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.addr <= '0;
            r_q.ce_n <= 1'b1;
            r_q.oe_n <= 1'b1;
            r_q.vld  <= 1'b0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.oe_n;
    assign rsp_valid = r_q.vld;
    assign rsp_data  = r_q.data;

    // R2: an accepted request drives its address with chip-enable low
    a_r2_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!mem_ce_n && mem_addr == $past(req_addr)));

    // R3: output-enable only inside a chip-enabled window
    a_r3_oe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R4: response strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: both enables released right after the response
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (mem_ce_n && mem_oe_n));

    // R5: address does not move during an access
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R6: ready never offered while the memory is selected
    a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

endmodule

// File: tb/tb_eprom_read_ctrl.sv
module tb_eprom_read_ctrl;
    localparam int LAG = 5, TOTAL = 10, OFF = 3;
    localparam int ACC_C = 10, CE_C = 10, OE_C = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n;
    logic [7:0]  rsp_data, mem_data;
    logic [12:0] mem_addr;

    always #10 clk = ~clk;

    eprom_read_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_data(mem_data)
    );

    int total = 0, bad = 0, n_sent = 0, n_rsp = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    function automatic logic [7:0] pat(logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: correct byte only when every age has reached its minimum.
    int a_age = 0, ce_age = 0, oe_age = 0;
    logic [12:0] last_a = '0;
    always @(negedge clk) begin
        if (mem_addr !== last_a) begin a_age = 1; last_a = mem_addr; end
        else a_age++;
        ce_age = mem_ce_n ? 0 : ce_age + 1;
        oe_age = mem_oe_n ? 0 : oe_age + 1;
    end
    assign mem_data = (!mem_ce_n && !mem_oe_n && a_age >= ACC_C && ce_age >= CE_C
                       && oe_age >= OE_C) ? pat(mem_addr) : 8'hEE;

    // Monitor: timing relations and scoreboard.
    int cyc = 0, ce_at = 0, rel_at = 0, min_gap = 1000;
    bit have_rel = 0, after_rsp = 0, prev_ce = 1, prev_oe = 1;
    logic [12:0] prev_addr = '0;
    logic [7:0]  held = '0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!mem_oe_n) chk(!mem_ce_n, "R3 oe only with ce", mem_ce_n, 0);
            if (after_rsp) begin
                chk(mem_ce_n && mem_oe_n, "R5 release", {mem_ce_n, mem_oe_n}, 3);
                chk(!rsp_valid, "R4 pulse width", rsp_valid, 0);
                chk(rsp_data == held, "R4 data hold", rsp_data, held);
                after_rsp = 0;
            end
            if (!mem_ce_n && prev_ce) begin
                ce_at = cyc;
                if (have_rel) begin
                    chk(cyc - rel_at >= OFF, "R6 float gap", cyc - rel_at, OFF);
                    if (cyc - rel_at < min_gap) min_gap = cyc - rel_at;
                end
            end
            if (!mem_ce_n && !prev_ce)
                chk(mem_addr == prev_addr, "R5 addr stable", mem_addr, prev_addr);
            if (mem_ce_n && !prev_ce) begin rel_at = cyc; have_rel = 1; end
            if (!mem_oe_n && prev_oe)
                chk(cyc - ce_at == LAG, "R3 oe lag", cyc - ce_at, LAG);
            if (rsp_valid) begin
                n_rsp++;
                chk(cyc - ce_at == TOTAL, "R4 latency", cyc - ce_at, TOTAL);
                if (exp_q.size() == 0) chk(0, "R7 extra response", rsp_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R4 data", rsp_data, e);
                end
                held = rsp_data;
                after_rsp = 1;
            end
        end
        prev_ce = mem_ce_n; prev_oe = mem_oe_n; prev_addr = mem_addr;
    end

    task automatic send(logic [12:0] a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        exp_q.push_back(pat(a));
        n_sent++;
        chk(!mem_ce_n && mem_addr == a, "R2 accept", mem_addr, a);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid, "R1 in reset", {mem_ce_n, mem_oe_n, rsp_valid}, 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 after reset",
            {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 13);
        // back-to-back
        send(13'h0000); send(13'h1FFF); send(13'h0AAA); send(13'h1555);
        // isolated
        repeat (20) @(negedge clk);
        send(13'h0123);
        repeat (15) @(negedge clk);
        send(13'h1C3E);
        // request held against a busy controller (R7)
        send(13'h0F0F);
        req_valid = 1'b1;
        req_addr  = 13'h1234;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(mem_ce_n && mem_addr != 13'h1234, "R7 ignored while busy", mem_ce_n, 1);
        end
        for (int i = 0; i < 6; i++) send(13'((i * 13'h0345) + 13'h0011));
        repeat (TOTAL + 8) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all answered", exp_q.size(), 0);
        chk(n_rsp == n_sent, "R7 response count", n_rsp, n_sent);
        chk(min_gap == OFF, "R6 back-to-back gap", min_gap, OFF);
        finish_run();
    end
endmodule